// File: doc/BRIEF.md
# Bunch-Aligned Capture Ring Buffer

This block sits in a sampled data path and records a stream of 32-bit words into an external synchronous RAM that is used as a circular buffer. Each word carries four consecutive 8-bit samples. The write pointer moves forward by one for every valid input word and returns to zero after a programmable wrap address. Software sets that address to a whole number of machine turns minus one, so a given RAM address always holds the same four bunch positions on every turn. As an example, a turn of 480 bunches with 1048576 words gives a wrap address of 0xFFFEF.

A two-bit route field decides where each valid word goes. Code 00 sends it to the output and to the buffer. Code 01 sends it to the output only. Code 10 replays the buffer to the output. Code 11 sends it to the buffer only. The pointer keeps moving with the incoming words while acquisition is off and in every route. Writing therefore resumes at the address of the current bunch, and playback reads the address of the current bunch. A stop register keeps the address of the most recent write across pauses. An output-hold bit, which is set after any reset, keeps the output port idle until software clears it.

A four-state controller sequences the datapath. IDLE issues nothing. STREAM writes and forwards words. PLAY issues buffer reads. DRAIN lets reads already in flight finish. The transitions are as follows. IDLE→STREAM occurs when acquisition is enabled with a route other than 10. IDLE→PLAY occurs when acquisition is enabled with route 10. STREAM→IDLE occurs when acquisition is disabled. STREAM→PLAY occurs when the route becomes 10. PLAY→DRAIN occurs when acquisition is disabled or the route leaves 10. DRAIN→IDLE, DRAIN→STREAM or DRAIN→PLAY occurs once no read is in flight, chosen by the current enable and route.

Top module: `ring_capture`

## Requirements
- R1: Every RAM write stores the valid input word unchanged (sample n in bits 31:24 through sample n+3 in bits 7:0) at the current pointer, one address per word.
- R2: The pointer steps 0,1,…,LAST and then returns to 0, where LAST is the value in register 1 (bits AW-1:0).
- R3: Register 2 reads the address of the most recent RAM write and keeps that value while acquisition is paused.
- R4: The pointer advances on every valid input word, whether acquisition is enabled or not and whatever the route.
- R5: With acquisition enabled and route 00 (control bits 5:4), each valid word is both written to the RAM and presented at the output.
- R6: With route 01, each valid word appears at the output and no RAM write occurs.
- R7: With route 10, each valid word issues a RAM read at the current pointer, and the RAM data appears at the output in word order, with no RAM writes.
- R8: With route 11, each valid word is written to the RAM and nothing appears at the output.
- R9: With acquisition enable (control bit 0) at 0, no RAM write, no RAM read and no output occur.
- R10: Writing 1 to control bit 31 returns every register to its default value and clears the pointer and the stop address to 0.
- R11: While the output-hold bit (control bit 12) is 1, out_valid stays low; RAM writes still follow the route.
- R12: After reset, register 0 (control) reads 0x00001000 and register 1 reads 2^AW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Four packed 8-bit samples |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index (0 control, 1 wrap address, 2 stop address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, RD_LAT cycles after the read |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |

## Verification
A pointer that skips, stalls or wraps at the wrong place shows up in two ways. Words land at the wrong RAM addresses, and playback returns data from the wrong bunch. Either one appears within one turn of the buffer, and the stop register exposes it at once. A controller stuck in the wrong state produces missing or unexpected output words, or writes that fall outside the route. The scoreboard detects these on the first affected word. After a board reset, stale register or pointer contents are visible on the next register read or the next write address.

// File: rtl/rcap_pkg.sv
package rcap_pkg;
    localparam int SAMPLE_W = 8;
    localparam int LANES    = 4;
    localparam int WORD_W   = SAMPLE_W * LANES;
    localparam int REG_AW   = 4;

    localparam logic [REG_AW-1:0] IDX_CTRL = 4'd0;
    localparam logic [REG_AW-1:0] IDX_WRAP = 4'd1;
    localparam logic [REG_AW-1:0] IDX_STOP = 4'd2;

    localparam int CB_ACQ   = 0;
    localparam int CB_RT_LO = 4;
    localparam int CB_RT_HI = 5;
    localparam int CB_HOLD  = 12;
    localparam int CB_BRST  = 31;

    typedef enum logic [1:0] {
        RT_BOTH = 2'b00,
        RT_OUT  = 2'b01,
        RT_PLAY = 2'b10,
        RT_BUF  = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_PLAY,
        ST_DRAIN
    } mode_e;
endpackage

// File: rtl/rcap_regs.sv
module rcap_regs
    import rcap_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [AW-1:0]     stop_addr,
    output logic              acq_en,
    output route_e            route,
    output logic              out_hold,
    output logic [AW-1:0]     wrap_addr,
    output logic              soft_clr
);
    localparam logic [AW-1:0] WRAP_DEFAULT = {AW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_en    <= 1'b0;
            route     <= RT_BOTH;
            out_hold  <= 1'b1;
            wrap_addr <= WRAP_DEFAULT;
            soft_clr  <= 1'b0;
        end else begin
            soft_clr <= 1'b0;
            if (reg_wr) begin
                unique case (reg_addr)
                    IDX_CTRL: begin
                        if (reg_wdata[CB_BRST]) begin
                            acq_en    <= 1'b0;
                            route     <= RT_BOTH;
                            out_hold  <= 1'b1;
                            wrap_addr <= WRAP_DEFAULT;
                            soft_clr  <= 1'b1;
                        end else begin
                            acq_en   <= reg_wdata[CB_ACQ];
                            route    <= route_e'(reg_wdata[CB_RT_HI:CB_RT_LO]);
                            out_hold <= reg_wdata[CB_HOLD];
                        end
                    end
                    IDX_WRAP: wrap_addr <= reg_wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            IDX_CTRL: begin
                reg_rdata[CB_ACQ]             = acq_en;
                reg_rdata[CB_RT_HI:CB_RT_LO]  = route;
                reg_rdata[CB_HOLD]            = out_hold;
            end
            IDX_WRAP: reg_rdata = 32'(wrap_addr);
            IDX_STOP: reg_rdata = 32'(stop_addr);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rcap_ptr.sv
module rcap_ptr #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          in_valid,
    input  logic [AW-1:0] wrap_addr,
    input  logic          wr_fire,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] stop_addr
);
    logic at_wrap;
    assign at_wrap = (ptr >= wrap_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (soft_clr) begin
            ptr <= '0;
        end else if (in_valid) begin
            ptr <= at_wrap ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_addr <= '0;
        end else if (soft_clr) begin
            stop_addr <= '0;
        end else if (wr_fire) begin
            stop_addr <= ptr;
        end
    end
endmodule

// File: rtl/rcap_router.sv
module rcap_router
    import rcap_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 32,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          acq_en,
    input  route_e        route,
    input  logic          out_hold,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_we,
    output logic          ram_re,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    mode_e state_q, state_d;
    logic [RD_LAT-1:0] rd_pipe;
    logic fwd;
    logic rd_busy;
    logic to_buf, to_out;

    assign rd_busy = |rd_pipe;
    assign to_buf  = (route == RT_BOTH) || (route == RT_BUF);
    assign to_out  = (route == RT_BOTH) || (route == RT_OUT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acq_en) state_d = (route == RT_PLAY) ? ST_PLAY : ST_STREAM;
            end
            ST_STREAM: begin
                if (!acq_en)               state_d = ST_IDLE;
                else if (route == RT_PLAY) state_d = ST_PLAY;
            end
            ST_PLAY: begin
                if (!acq_en || route != RT_PLAY) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!rd_busy) begin
                    if (!acq_en)               state_d = ST_IDLE;
                    else if (route == RT_PLAY) state_d = ST_PLAY;
                    else                       state_d = ST_STREAM;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_IDLE;
        else if (soft_clr) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        fwd       = 1'b0;
        ram_addr  = ptr;
        ram_wdata = in_data;
        unique case (state_q)
            ST_STREAM: begin
                ram_we = acq_en && in_valid && to_buf;
                fwd    = acq_en && in_valid && to_out;
            end
            ST_PLAY: begin
                ram_re = acq_en && in_valid && (route == RT_PLAY);
            end
            default: ;
        endcase
    end

    generate
        if (RD_LAT == 1) begin : g_lat1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        rd_pipe <= '0;
                else if (soft_clr) rd_pipe <= '0;
                else               rd_pipe <= ram_re;
            end
        end else begin : g_latn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        rd_pipe <= '0;
                else if (soft_clr) rd_pipe <= '0;
                else               rd_pipe <= {rd_pipe[RD_LAT-2:0], ram_re};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (soft_clr || out_hold) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (rd_pipe[RD_LAT-1]) begin
            out_valid <= 1'b1;
            out_data  <= ram_rdata;
        end else if (fwd) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_capture.sv
module ring_capture
    import rcap_pkg::*;
#(
    parameter int AW     = 20,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ram_we,
    output logic              ram_re,
    output logic [AW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic          acq_en;
    route_e        route;
    logic          out_hold;
    logic [AW-1:0] wrap_addr;
    logic          soft_clr;
    logic [AW-1:0] ptr;
    logic [AW-1:0] stop_addr;

    rcap_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stop_addr (stop_addr),
        .acq_en    (acq_en),
        .route     (route),
        .out_hold  (out_hold),
        .wrap_addr (wrap_addr),
        .soft_clr  (soft_clr)
    );

    rcap_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .in_valid  (in_valid),
        .wrap_addr (wrap_addr),
        .wr_fire   (ram_we),
        .ptr       (ptr),
        .stop_addr (stop_addr)
    );

    rcap_router #(.AW(AW), .DW(WORD_W), .RD_LAT(RD_LAT)) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .acq_en    (acq_en),
        .route     (route),
        .out_hold  (out_hold),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .ptr       (ptr),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/rcap_chk.sv
module rcap_chk #(
    parameter int AW = 20,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          ram_we,
    input logic          ram_re,
    input logic [AW-1:0] ram_addr,
    input logic [DW-1:0] ram_wdata,
    input logic          out_valid,
    input logic          out_hold,
    input logic          acq_en,
    input logic [1:0]    route,
    input logic [AW-1:0] wrap_addr,
    input logic [AW-1:0] ptr,
    input logic [AW-1:0] stop_addr
);
    // R1
    wr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (in_valid && ram_wdata == in_data && ram_addr == ptr));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !soft_clr && ptr >= wrap_addr) |=> (ptr == '0));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !soft_clr && ptr < wrap_addr) |=> (ptr == AW'($past(ptr) + 1'b1)));

    // R3
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !soft_clr) |=> (stop_addr == $past(ram_addr)));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |-> (!ram_we && !ram_re));

    // R6
    route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (route == 2'b00 || route == 2'b11));

    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hold |=> !out_valid);
endmodule

bind ring_capture rcap_chk #(.AW(AW), .DW(rcap_pkg::WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .out_valid (out_valid),
    .out_hold  (out_hold),
    .acq_en    (acq_en),
    .route     (route),
    .wrap_addr (wrap_addr),
    .ptr       (ptr),
    .stop_addr (stop_addr)
);

// File: tb/tb_ring_capture.sv
`timescale 1ns/1ps
module tb_ring_capture;
    localparam int AW     = 6;
    localparam int DEPTH  = 1 << AW;
    localparam int RD_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ram_we, ram_re;
    logic [AW-1:0] ram_addr;
    logic [31:0] ram_wdata, ram_rdata;
    logic        out_valid;
    logic [31:0] out_data;

    always #2.5 clk = ~clk;

    ring_capture #(.AW(AW), .RD_LAT(RD_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .out_valid(out_valid), .out_data(out_data)
    );

    // behavioural RAM with RD_LAT cycles of read latency
    logic [31:0] mem [DEPTH];
    logic [31:0] rp0, rp1;
    int          wr_count = 0;
    initial for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (ram_re) rp0 <= mem[ram_addr];
        rp1 <= rp0;
        if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
            wr_count <= wr_count + 1;
        end
    end
    assign ram_rdata = rp1;

    int n_checks = 0;
    int n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // model state derived from the requirements
    logic [31:0] shadow [DEPTH];
    int  m_ptr = 0;
    int  m_last = DEPTH - 1;
    bit  m_acq = 0;
    bit  m_hold = 1;
    int  m_route = 0;
    int  m_writes = 0;
    int  m_lastwr = 0;
    initial for (int i = 0; i < DEPTH; i++) shadow[i] = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares outputs against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected output word", out_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_data == e, t, out_data, e);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            reg_wr = 1'b0;
        end
    endtask

    task automatic send(input logic [31:0] d);
        string tag;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        tag = (m_route == 0) ? "R5" : (m_route == 1) ? "R6" : "R7";
        if (m_acq && !m_hold && m_route != 3) begin
            exp_q.push_back((m_route == 2) ? shadow[m_ptr] : d);
            tag_q.push_back(tag);
        end
        if (m_acq && (m_route == 0 || m_route == 3)) begin
            shadow[m_ptr] = d;
            m_writes++;
            m_lastwr = m_ptr;
        end
        m_ptr = (m_ptr >= m_last) ? 0 : m_ptr + 1;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid  = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        idle(4);
    endtask

    task automatic set_ctrl(input bit acq, input int rt, input bit hold);
        reg_write(4'd0, {19'd0, hold, 6'd0, 2'(rt), 3'd0, acq});
        m_acq = acq; m_route = rt; m_hold = hold;
    endtask

    task automatic reg_check(input logic [3:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    bit done = 0;
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R12 out_valid in reset", 32'(out_valid), 0);
        chk(ram_we == 1'b0, "R9 ram_we in reset", 32'(ram_we), 0);
        rst_n = 1'b1;
        idle(2);
        reg_check(4'd0, 32'h0000_1000, "R12 control default");
        reg_check(4'd1, 32'(DEPTH - 1), "R12 wrap default");
        reg_check(4'd2, 32'h0, "R3 stop default");

        // capture to buffer only, 14 words across a wrap at 11
        reg_write(4'd1, 32'd11);
        m_last = 11;
        set_ctrl(1, 3, 0);
        for (int i = 0; i < 14; i++) send(32'hA000_0000 + 32'(i));
        idle(4);
        chk(wr_count == m_writes, "R8 write count", 32'(wr_count), 32'(m_writes));
        chk(mem[0] == 32'hA000_000C, "R2 wrap overwrites address 0", mem[0], 32'hA000_000C);
        chk(mem[1] == 32'hA000_000D, "R1 word stored whole", mem[1], 32'hA000_000D);
        reg_check(4'd2, 32'(m_lastwr), "R3 stop address after capture");

        // pause: pointer keeps moving, nothing happens
        set_ctrl(0, 3, 0);
        for (int i = 0; i < 5; i++) send(32'hBB00_0000 + 32'(i));
        idle(4);
        chk(wr_count == m_writes, "R9 no write while paused", 32'(wr_count), 32'(m_writes));
        reg_check(4'd2, 32'(m_lastwr), "R3 stop address held while paused");

        // resume with both destinations
        set_ctrl(1, 0, 0);
        for (int i = 0; i < 6; i++) send(32'hC100_0000 + 32'(i * 3));
        idle(4);
        chk(wr_count == m_writes, "R5 write count", 32'(wr_count), 32'(m_writes));
        for (int a = 0; a <= 11; a++)
            chk(mem[a] == shadow[a], "R4 resume address matches bunch", mem[a], shadow[a]);

        // output only
        set_ctrl(1, 1, 0);
        for (int i = 0; i < 4; i++) send(32'hD200_0000 + 32'(i));
        idle(4);
        chk(wr_count == m_writes, "R6 no write in output-only route", 32'(wr_count), 32'(m_writes));

        // playback over a full turn
        set_ctrl(1, 2, 0);
        for (int i = 0; i < 12; i++) send(32'hEEEE_0000 + 32'(i));
        idle(6);
        chk(wr_count == m_writes, "R7 no write in playback", 32'(wr_count), 32'(m_writes));

        // output hold
        set_ctrl(1, 0, 1);
        for (int i = 0; i < 3; i++) send(32'hF300_0000 + 32'(i));
        idle(4);
        chk(wr_count == m_writes, "R11 writes continue under hold", 32'(wr_count), 32'(m_writes));

        // board reset
        reg_write(4'd0, 32'h8000_0000);
        m_ptr = 0; m_last = DEPTH - 1; m_acq = 0; m_route = 0; m_hold = 1;
        reg_check(4'd0, 32'h0000_1000, "R10 control restored");
        reg_check(4'd1, 32'(DEPTH - 1), "R10 wrap restored");
        reg_check(4'd2, 32'h0, "R10 stop cleared");
        set_ctrl(1, 3, 0);
        send(32'h5A5A_1234);
        idle(4);
        reg_check(4'd2, 32'h0, "R10 pointer back at base");
        chk(mem[0] == 32'h5A5A_1234, "R10 first write at address 0", mem[0], 32'h5A5A_1234);

        idle(4);
        chk(exp_q.size() == 0, "R7 all expected outputs seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule